// File: doc/BRIEF.md
# Packet-Aware Receive FIFO

This block sits between a receive MAC and a host-side reader. Each incoming byte is stored together with a flag that is set on the final byte of its frame. As a result, frame boundaries survive the trip through the buffer. Two occupancy thresholds, a low one and a high one, are compared against the fill level. The high indication also rises whenever at least one whole frame is buffered. A frame shorter than the high threshold is therefore never stranded.

A built-in reader state machine starts a transfer when the high indication is present. It then hands bytes to the host whenever the host is ready, and it raises an end-of-frame strobe alongside the final byte of each frame. Three transfer modes decide where a transfer stops:

- **Packet mode** runs to the end of the frame.
- **Block mode** stops after a programmed byte count, or earlier at an end of frame.
- **Drain mode** stops at an end of frame or when the buffer runs dry.

Configure the system in one of these ways:

- For whole-frame transfers, set the high threshold above the largest frame. Only completed frames then wake the reader.
- For fixed-size transfers, set the high threshold to the block size.

Top module: `rxPktFifo`

## Requirements
- R1: After reset the following are all low: `lowWm`, `highWm`, `overflow`, `rdValid` and `xferDone`. `framesHeld` is zero.
- R2: Bytes leave in the order they were written. `rdEof` is high together with `rdValid` exactly when the presented byte was written with `wrLast` high.
- R3: `lowWm` is high exactly when the number of stored bytes is greater than or equal to `lowThresh`.
- R4: `highWm` is high exactly when the stored byte count is greater than or equal to `highThresh`, or `framesHeld` is nonzero.
- R5: A write while `DEPTH` bytes are stored is discarded. The discarded write sets `overflow`, which stays high until reset, and the stored contents are unchanged.
- R6: While a transfer is active and the buffer is empty, `rdValid` is low. Asserting `hostReady` then consumes nothing and changes no state.
- R7: With `readMode` = 0 (packet), a transfer starts while `highWm` is high. A byte is consumed on each clock edge where `rdValid` and `hostReady` are both high. The transfer ends with the byte that carries `rdEof`. `xferDone` is then high for exactly one cycle.
- R8: With `readMode` = 1 (block), a transfer ends after `blockSize` bytes (`blockSize` at least 1) or at an `rdEof` byte, whichever comes first. The count restarts at zero for every transfer.
- R9: With `readMode` = 2 (drain), a transfer ends at an `rdEof` byte, or after a read that leaves the buffer empty with no write in the same cycle.
- R10: `framesHeld` counts stored bytes that were written with `wrLast` high. When such a byte is written and another is read in the same cycle, the count is unchanged.
- R11: While `hostReady` is low, the presented byte and `rdValid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe from the MAC |
| wrData | input | DATA_W | Byte to store |
| wrLast | input | 1 | Marks the final byte of a frame |
| lowThresh | input | CNT_W | Low occupancy threshold |
| highThresh | input | CNT_W | High occupancy threshold |
| readMode | input | 2 | 0 packet, 1 block, 2 drain |
| blockSize | input | CNT_W | Byte limit for block mode |
| hostReady | input | 1 | Host accepts the presented byte |
| rdValid | output | 1 | A byte is presented to the host |
| rdData | output | DATA_W | Presented byte |
| rdEof | output | 1 | Presented byte ends a frame |
| xferDone | output | 1 | One-cycle pulse after a transfer ends |
| lowWm | output | 1 | Occupancy at or above the low threshold |
| highWm | output | 1 | High threshold reached or a whole frame held |
| framesHeld | output | CNT_W | Number of complete frames stored |
| overflow | output | 1 | Sticky flag for a discarded write |

## Verification
The bench targets the following cases, each with the failure it would expose:

- **Short frame below the high threshold.** A design that only compares occupancy would never wake the reader.
- **Frame longer than the block size.** This must split into a full block and a remainder. An unreset block counter would cut the second transfer short.
- **Full buffer.** A write into a full buffer would corrupt the oldest byte or the end marker if not discarded.
- **Read attempts against an empty buffer.** These would underflow the pointers and replay stale data.
- **End-of-frame byte written in the same cycle another leaves.** A counter that handles only one event would lose or invent a frame.
- **Drain mode with data left after an end of frame.** An early wake-up would show up here.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

  typedef enum logic [1:0] {
    MODE_PACKET = 2'd0,
    MODE_BLOCK  = 2'd1,
    MODE_DRAIN  = 2'd2
  } readMode_e;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_READ = 2'd1,
    RD_DONE = 2'd2
  } rdState_e;

  // strobes from reader control to storage
  typedef struct packed {
    logic pop;
  } ctlStrobe_t;

  // status from storage to reader control
  typedef struct packed {
    logic empty;
    logic headEof;
    logic pushing;
    logic lastEntry;
    logic highWm;
  } fifoStat_t;

endpackage

// File: rtl/rxpf_store.sv
module rxpf_store
  import rxpf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic [CNT_W-1:0]  lowThresh,
  input  logic [CNT_W-1:0]  highThresh,
  input  ctlStrobe_t        strobe,
  output fifoStat_t         stat,
  output logic [DATA_W-1:0] headData,
  output logic              lowWm,
  output logic              highWm,
  output logic [CNT_W-1:0]  framesHeld,
  output logic              overflow
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_PTR = ADDR_W'(DEPTH - 1);

  logic [DATA_W:0]   mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              full, empty, push, pop;
  logic              frameIn, frameOut;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign push     = wrValid && !full;
  assign pop      = strobe.pop && !empty;
  assign frameIn  = push && wrLast;
  assign frameOut = pop && mem[rdPtr][DATA_W];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {wrLast, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + ADDR_W'(1);
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      framesHeld <= '0;
    end else begin
      case ({frameIn, frameOut})
        2'b10:   framesHeld <= framesHeld + CNT_W'(1);
        2'b01:   framesHeld <= framesHeld - CNT_W'(1);
        default: framesHeld <= framesHeld;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                overflow <= 1'b0;
    else if (wrValid && full) overflow <= 1'b1;
  end

  assign lowWm    = (count >= lowThresh);
  assign highWm   = (count >= highThresh) || (framesHeld != '0);
  assign headData = mem[rdPtr][DATA_W-1:0];

  always_comb begin
    stat.empty     = empty;
    stat.headEof   = !empty && mem[rdPtr][DATA_W];
    stat.pushing   = push;
    stat.lastEntry = (count == CNT_W'(1));
    stat.highWm    = highWm;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);  // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrValid && !strobe.pop) |=> $stable(count));  // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);  // R5
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !empty);  // R6
  AST_FRAMES_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    framesHeld <= count);  // R10
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !strobe.pop) |=> (headData == $past(headData)));  // R11

endmodule

// File: rtl/rxpf_reader.sv
module rxpf_reader
  import rxpf_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       readMode,
  input  logic [CNT_W-1:0] blockSize,
  input  logic             hostReady,
  input  fifoStat_t        stat,
  output ctlStrobe_t       strobe,
  output logic             rdValid,
  output logic             rdEof,
  output logic             xferDone
);

  rdState_e         state, stateNext;
  logic [CNT_W-1:0] byteCnt;
  readMode_e        mode;
  logic             pop, blockHit, drainHit, endNow;

  assign mode     = readMode_e'(readMode);
  assign rdValid  = (state == RD_READ) && !stat.empty;
  assign rdEof    = rdValid && stat.headEof;
  assign pop      = rdValid && hostReady;
  assign blockHit = (mode == MODE_BLOCK) && ((byteCnt + CNT_W'(1)) == blockSize);
  assign drainHit = (mode == MODE_DRAIN) && stat.lastEntry && !stat.pushing;
  assign endNow   = pop && (stat.headEof || blockHit || drainHit);
  assign xferDone = (state == RD_DONE);

  always_comb begin
    strobe.pop = pop;
  end

  always_comb begin
    stateNext = state;
    case (state)
      RD_IDLE: if (stat.highWm) stateNext = RD_READ;
      RD_READ: if (endNow)      stateNext = RD_DONE;
      RD_DONE:                  stateNext = RD_IDLE;
      default:                  stateNext = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RD_IDLE;
      byteCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == RD_IDLE) byteCnt <= '0;
      else if (pop)         byteCnt <= byteCnt + CNT_W'(1);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (state == RD_DONE) |=> (state == RD_IDLE));  // R7
  AST_BLOCK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == RD_READ && mode == MODE_BLOCK && blockSize != '0) |-> (byteCnt < blockSize));  // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !hostReady) |=> rdValid);  // R11
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stat.empty |-> !pop);  // R6

endmodule

// File: rtl/rxPktFifo.sv
module rxPktFifo
  import rxpf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic [CNT_W-1:0]  lowThresh,
  input  logic [CNT_W-1:0]  highThresh,
  input  logic [1:0]        readMode,
  input  logic [CNT_W-1:0]  blockSize,
  input  logic              hostReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEof,
  output logic              xferDone,
  output logic              lowWm,
  output logic              highWm,
  output logic [CNT_W-1:0]  framesHeld,
  output logic              overflow
);

  ctlStrobe_t strobe;
  fifoStat_t  stat;

  rxpf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uStore (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .wrData     (wrData),
    .wrLast     (wrLast),
    .lowThresh  (lowThresh),
    .highThresh (highThresh),
    .strobe     (strobe),
    .stat       (stat),
    .headData   (rdData),
    .lowWm      (lowWm),
    .highWm     (highWm),
    .framesHeld (framesHeld),
    .overflow   (overflow)
  );

  rxpf_reader #(.CNT_W(CNT_W)) uReader (
    .clk       (clk),
    .rstN      (rstN),
    .readMode  (readMode),
    .blockSize (blockSize),
    .hostReady (hostReady),
    .stat      (stat),
    .strobe    (strobe),
    .rdValid   (rdValid),
    .rdEof     (rdEof),
    .xferDone  (xferDone)
  );

endmodule

// File: tb/tb_rxPktFifo.sv
module tb_rxPktFifo;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrValid, wrLast, hostReady;
  logic [DATA_W-1:0] wrData;
  logic [CNT_W-1:0]  lowThresh, highThresh, blockSize;
  logic [1:0]        readMode;
  logic              rdValid, rdEof, xferDone, lowWm, highWm, overflow;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0]  framesHeld;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  rxPktFifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrLast(wrLast),
    .lowThresh(lowThresh), .highThresh(highThresh), .readMode(readMode),
    .blockSize(blockSize), .hostReady(hostReady), .rdValid(rdValid),
    .rdData(rdData), .rdEof(rdEof), .xferDone(xferDone), .lowWm(lowWm),
    .highWm(highWm), .framesHeld(framesHeld), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] d, input logic last);
    wrValid = 1'b1; wrData = d; wrLast = last;
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0;
  endtask

  task automatic readByte(input logic [7:0] d, input logic eof, input string tag);
    for (int n = 0; n < 8 && !rdValid; n++) @(negedge clk);
    chk({tag, " rdValid"}, rdValid, 1);
    chk({tag, " rdData"}, rdData, d);
    chk({tag, " rdEof"}, rdEof, eof);
    hostReady = 1'b1;
    @(negedge clk);
    hostReady = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 lowWm", lowWm, 0);
    chk("R1 highWm", highWm, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 rdValid", rdValid, 0);
    chk("R1 xferDone", xferDone, 0);
    chk("R1 framesHeld", framesHeld, 0);
  endtask

  task automatic testThresholds();
    readMode = 2'd0; lowThresh = 4; highThresh = 12;
    for (int i = 0; i < 3; i++) pushByte(8'h10 + 8'(i), 0);
    chk("R3 below low", lowWm, 0);
    pushByte(8'h13, 0);
    chk("R3 at low", lowWm, 1);
    chk("R4 below high", highWm, 0);
    for (int i = 4; i < 11; i++) pushByte(8'h10 + 8'(i), 0);
    chk("R4 eleven bytes", highWm, 0);
    pushByte(8'h1B, 0);
    chk("R4 at high", highWm, 1);
    pushByte(8'h1C, 1);
    chk("R10 one frame", framesHeld, 1);
    for (int i = 0; i < 13; i++) readByte(8'h10 + 8'(i), i == 12, "R2 R7 packet");
    chk("R7 done pulse", xferDone, 1);
    chk("R10 frame gone", framesHeld, 0);
    chk("R3 empty low", lowWm, 0);
    @(negedge clk);
    chk("R7 done one cycle", xferDone, 0);
    chk("R7 idle no data", rdValid, 0);
  endtask

  task automatic testShortFrame();
    pushByte(8'hA0, 0); pushByte(8'hA1, 0); pushByte(8'hA2, 1);
    chk("R4 short frame high", highWm, 1);
    chk("R3 short frame low", lowWm, 0);
    for (int n = 0; n < 8 && !rdValid; n++) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      chk("R11 stall valid", rdValid, 1);
      chk("R11 stall data", rdData, 8'hA0);
      @(negedge clk);
    end
    readByte(8'hA0, 0, "R2 short");
    readByte(8'hA1, 0, "R2 short");
    readByte(8'hA2, 1, "R2 short");
    chk("R7 short done", xferDone, 1);
  endtask

  task automatic testBlock();
    @(negedge clk);
    readMode = 2'd1; blockSize = 4;
    for (int i = 0; i < 6; i++) pushByte(8'h30 + 8'(i), i == 5);
    for (int i = 0; i < 4; i++) readByte(8'h30 + 8'(i), 0, "R8 block");
    chk("R8 block limit", xferDone, 1);
    readByte(8'h34, 0, "R8 second block");
    chk("R8 counter restart", xferDone, 0);
    readByte(8'h35, 1, "R8 second block");
    chk("R8 eof ends block", xferDone, 1);
    pushByte(8'h40, 0); pushByte(8'h41, 1);
    readByte(8'h40, 0, "R8 short block");
    readByte(8'h41, 1, "R8 short block");
    chk("R8 eof before limit", xferDone, 1);
  endtask

  task automatic testDrain();
    @(negedge clk);
    readMode = 2'd2; highThresh = 3;
    for (int i = 0; i < 5; i++) pushByte(8'h50 + 8'(i), 0);
    for (int i = 0; i < 5; i++) readByte(8'h50 + 8'(i), 0, "R9 drain");
    chk("R9 empty ends", xferDone, 1);
    pushByte(8'h60, 0); pushByte(8'h61, 1); pushByte(8'h62, 0);
    readByte(8'h60, 0, "R9 drain eof");
    readByte(8'h61, 1, "R9 drain eof");
    chk("R9 eof ends", xferDone, 1);
    @(negedge clk); @(negedge clk);
    chk("R4 leftover no high", highWm, 0);
    chk("R9 leftover idle", rdValid, 0);
    pushByte(8'h63, 0); pushByte(8'h64, 0);
    readByte(8'h62, 0, "R9 drain rest");
    readByte(8'h63, 0, "R9 drain rest");
    readByte(8'h64, 0, "R9 drain rest");
    chk("R9 rest ends", xferDone, 1);
  endtask

  task automatic testOverflow();
    @(negedge clk);
    readMode = 2'd0; highThresh = 16;
    chk("R5 no overflow yet", overflow, 0);
    for (int i = 0; i < 16; i++) pushByte(8'h80 + 8'(i), i == 15);
    pushByte(8'hEE, 1);
    chk("R5 overflow set", overflow, 1);
    chk("R5 frame count kept", framesHeld, 1);
    for (int i = 0; i < 16; i++) readByte(8'h80 + 8'(i), i == 15, "R5 contents");
    chk("R5 done", xferDone, 1);
    @(negedge clk);
    chk("R5 dropped byte absent", rdValid, 0);
    chk("R5 overflow sticky", overflow, 1);
  endtask

  task automatic testEmptyRead();
    highThresh = 2;
    pushByte(8'h90, 0); pushByte(8'h91, 0);
    readByte(8'h90, 0, "R6 setup");
    readByte(8'h91, 0, "R6 setup");
    hostReady = 1'b1;
    for (int n = 0; n < 3; n++) begin
      chk("R6 empty no valid", rdValid, 0);
      @(negedge clk);
    end
    hostReady = 1'b0;
    chk("R6 frames untouched", framesHeld, 0);
    pushByte(8'h92, 1);
    readByte(8'h92, 1, "R6 after empty");
    chk("R6 done", xferDone, 1);
  endtask

  task automatic testCancel();
    @(negedge clk);
    highThresh = 16;
    pushByte(8'hA5, 1);
    for (int n = 0; n < 8 && !rdValid; n++) @(negedge clk);
    chk("R10 head data", rdData, 8'hA5);
    chk("R10 head eof", rdEof, 1);
    wrValid = 1'b1; wrData = 8'hA6; wrLast = 1'b1; hostReady = 1'b1;
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0; hostReady = 1'b0;
    chk("R10 simultaneous cancel", framesHeld, 1);
    chk("R7 cancel done", xferDone, 1);
    readByte(8'hA6, 1, "R10 second frame");
    chk("R10 final count", framesHeld, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrValid = 1'b0; wrData = '0; wrLast = 1'b0; hostReady = 1'b0;
    lowThresh = 4; highThresh = 12; readMode = 2'd0; blockSize = 4;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testThresholds();
    testShortFrame();
    testBlock();
    testDrain();
    testOverflow();
    testEmptyRead();
    testCancel();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule